// File: doc/BRIEF.md
# UART Receive Buffer with Character Timeout

This block holds the bytes a serial receiver has deserialised until software reads them. It sits between a receiver, which presents one byte or one break event per cycle, and the register read path of a 16550-style UART. In buffered mode it keeps up to sixteen bytes in arrival order. In unbuffered mode it keeps a single holding register. It reports how many bytes are waiting, whether data is ready, whether a break or an overrun was seen, and whether bytes have sat unread for too long.

A control write selects buffered or unbuffered operation, empties the buffer on request and picks an interrupt trigger level. The trigger level shapes a receive-room figure that tells the receiver how many more bytes to offer. A character-time input, given in clock cycles, sets the idle window after which a timeout is flagged. Interrupt priority and the serial line itself are handled elsewhere.

Top module: `uart_rx_buffer`

## Requirements
- R1: The trigger level comes from `cfg_trig` (0 gives 1 byte, 1 gives 4, 2 gives 8, 3 gives 14). In buffered mode `rx_room` is the level minus the count while the count is at or below the level, 1 while it is above, and 0 when the buffer holds 16 bytes. In unbuffered mode `rx_room` is 1 when no data is ready and 0 otherwise.
- R2: In buffered mode a byte that arrives while 16 bytes are stored, after any read in the same cycle, is dropped and sets `overrun`. Stored bytes are never replaced.
- R3: A control write whose `cfg_fifo_en` differs from the current mode switches the mode and performs a full receive clear, as in R4.
- R4: A control write with `cfg_rx_reset` set empties the buffer, clears data ready, break and timeout-pending, and stops the timeout counter. It leaves `overrun` alone. Receive and read inputs in that cycle are ignored.
- R5: A break event stores a 0x00 byte, subject to R2, and sets both `break_seen` and `data_ready`.
- R6: Bytes are read out in arrival order. `rd_data` shows the oldest byte and shows 0x00 when the buffered mode is empty. A read that leaves the count at zero clears `data_ready` and `break_seen`.
- R7: In buffered mode each arrival, and each read that leaves data behind, restarts an idle counter. When the counter reaches 4 x `char_cycles` clock edges with no restart and the buffer is not empty, `timeout_pend` is set.
- R8: Any read clears `timeout_pend`.
- R9: In unbuffered mode an arrival overwrites the holding register, sets `data_ready`, and sets `overrun` if data was already ready. A read clears `data_ready` and `break_seen`.
- R10: `stat_rd` clears `overrun` and `break_seen`. A new overrun or break in the same cycle wins over the clear.
- R11: After reset the block is in unbuffered mode with trigger level 1. The count is 0, all flags are low and `rx_room` is 1.
- R12: When a read and an arrival fall in the same cycle, the read is served first and the new byte is then stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | A received byte is presented this cycle |
| rx_data | input | 8 | Received byte |
| rx_break | input | 1 | Break event from the receiver; takes the place of a byte |
| rd_en | input | 1 | Read of the receive buffer register |
| rd_data | output | 8 | Oldest byte (buffered) or holding register (unbuffered) |
| stat_rd | input | 1 | Line-status read; clears overrun and break |
| cfg_wr | input | 1 | Control write strobe |
| cfg_fifo_en | input | 1 | Buffered mode select carried by the control write |
| cfg_rx_reset | input | 1 | Receive clear request carried by the control write |
| cfg_trig | input | 2 | Trigger level select carried by the control write |
| char_cycles | input | 16 | Character time in clock cycles (at least 1) |
| rx_count | output | 5 | Bytes waiting |
| data_ready | output | 1 | At least one byte is ready |
| break_seen | output | 1 | A break was received |
| overrun | output | 1 | A byte was lost |
| timeout_pend | output | 1 | Data left unread past the idle window |
| rx_room | output | 5 | Bytes the receiver may offer |

## Verification
Several rules are checked on every cycle: a full buffer does not grow and flags overrun, a clear or mode switch always leaves an empty buffer with data ready low, a break always raises break and data ready, a read always drops the timeout flag, and a full buffer offers no room. The exact idle window length, the arrival order of bytes across a fill and drain, the trigger-level room values, and the same-cycle ordering of read, arrival and status clear are shown only by the bench's scenarios against its reference model.

// File: rtl/urb_pkg.sv
package urb_pkg;

    typedef enum logic [1:0] {
        TRIG_1  = 2'd0,
        TRIG_4  = 2'd1,
        TRIG_8  = 2'd2,
        TRIG_14 = 2'd3
    } trig_sel_e;

    typedef struct packed {
        logic ready;
        logic brk;
        logic ovr;
        logic pend;
    } rx_flags_t;

    function automatic logic [7:0] trig_bytes(trig_sel_e sel);
        case (sel)
            TRIG_1:  return 8'd1;
            TRIG_4:  return 8'd4;
            TRIG_8:  return 8'd8;
            default: return 8'd14;
        endcase
    endfunction

endpackage

// File: rtl/urb_store.sv
module urb_store #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count
);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;

    function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            count <= count + CW'(push) - CW'(pop);
        end
    end

    assign head = mem[rd_ptr];

endmodule

// File: rtl/urb_timer.sv
module urb_timer #(
    parameter int CCW  = 16,
    localparam int TW  = CCW + 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           clr,
    input  logic           restart,
    input  logic [CCW-1:0] char_cycles,
    output logic           expire
);

    logic          armed;
    logic [TW-1:0] tmr;
    logic [TW-1:0] limit;

    assign limit  = {char_cycles, 2'b00};
    assign expire = armed && !restart && !clr && (tmr == limit - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            armed <= 1'b0;
            tmr   <= '0;
        end else if (restart) begin
            armed <= 1'b1;
            tmr   <= '0;
        end else if (expire) begin
            armed <= 1'b0;
        end else if (armed) begin
            tmr <= tmr + 1'b1;
        end
    end

endmodule

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer
    import urb_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    parameter int CCW   = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           rx_valid,
    input  logic [DW-1:0]  rx_data,
    input  logic           rx_break,
    input  logic           rd_en,
    output logic [DW-1:0]  rd_data,
    input  logic           stat_rd,
    input  logic           cfg_wr,
    input  logic           cfg_fifo_en,
    input  logic           cfg_rx_reset,
    input  logic [1:0]     cfg_trig,
    input  logic [CCW-1:0] char_cycles,
    output logic [CW-1:0]  rx_count,
    output logic           data_ready,
    output logic           break_seen,
    output logic           overrun,
    output logic           timeout_pend,
    output logic [CW-1:0]  rx_room
);

    logic          fifo_on;
    trig_sel_e     trig;
    rx_flags_t     flags, flags_n;
    logic [DW-1:0] hold_q;

    logic          ctl_clear, live, take;
    logic [DW-1:0] in_byte, q_head;
    logic [CW-1:0] q_count, left, lvl;
    logic          q_push, q_pop, t_restart, t_expire;

    always_comb begin
        ctl_clear = cfg_wr && (cfg_rx_reset || (cfg_fifo_en != fifo_on));
        live      = !ctl_clear;
        take      = rx_valid || rx_break;
        in_byte   = rx_break ? '0 : rx_data;
        q_pop     = live && fifo_on && rd_en && (q_count != '0);
        left      = q_count - CW'(q_pop);
        q_push    = live && fifo_on && take && (left != CW'(DEPTH));
        t_restart = live && fifo_on && ((rd_en && left != '0) || take);
        lvl       = CW'(trig_bytes(trig));
    end

    urb_store #(.DEPTH(DEPTH), .DW(DW)) store_i (
        .clk   (clk),
        .rst   (rst),
        .clr   (ctl_clear),
        .push  (q_push),
        .pop   (q_pop),
        .wdata (in_byte),
        .head  (q_head),
        .count (q_count)
    );

    urb_timer #(.CCW(CCW)) timer_i (
        .clk         (clk),
        .rst         (rst),
        .clr         (ctl_clear),
        .restart     (t_restart),
        .char_cycles (char_cycles),
        .expire      (t_expire)
    );

    // Next flag state for a cycle without a clear: status clear, then read, then arrival.
    always_comb begin
        flags_n = flags;
        if (stat_rd) begin
            flags_n.ovr = 1'b0;
            flags_n.brk = 1'b0;
        end
        if (rd_en) begin
            flags_n.pend = 1'b0;
            if (!fifo_on || left == '0) begin
                flags_n.ready = 1'b0;
                flags_n.brk   = 1'b0;
            end
        end
        if (take) begin
            if (fifo_on ? (left == CW'(DEPTH)) : flags_n.ready) flags_n.ovr = 1'b1;
            flags_n.ready = 1'b1;
            if (rx_break) flags_n.brk = 1'b1;
        end
        if (t_expire && q_count != '0 && !rd_en) flags_n.pend = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags   <= '0;
            fifo_on <= 1'b0;
            trig    <= TRIG_1;
            hold_q  <= '0;
        end else if (ctl_clear) begin
            flags.ready <= 1'b0;
            flags.brk   <= 1'b0;
            flags.pend  <= 1'b0;
            fifo_on     <= cfg_fifo_en;
            trig        <= trig_sel_e'(cfg_trig);
        end else begin
            flags <= flags_n;
            if (cfg_wr) trig <= trig_sel_e'(cfg_trig);
            if (!fifo_on && take) hold_q <= in_byte;
        end
    end

    always_comb begin
        if (fifo_on) begin
            rx_count = q_count;
            rd_data  = (q_count != '0) ? q_head : '0;
            if (q_count == CW'(DEPTH))  rx_room = '0;
            else if (q_count <= lvl)    rx_room = lvl - q_count;
            else                        rx_room = CW'(1);
        end else begin
            rx_count = CW'(flags.ready);
            rd_data  = hold_q;
            rx_room  = flags.ready ? '0 : CW'(1);
        end
    end

    assign data_ready   = flags.ready;
    assign break_seen   = flags.brk;
    assign overrun      = flags.ovr;
    assign timeout_pend = flags.pend;

endmodule

// File: rtl/urb_checker.sv
module urb_checker #(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          fifo_on,
    input logic          cfg_wr,
    input logic          cfg_fifo_en,
    input logic          cfg_rx_reset,
    input logic          rx_valid,
    input logic          rx_break,
    input logic          rd_en,
    input logic [CW-1:0] rx_count,
    input logic          data_ready,
    input logic          break_seen,
    input logic          overrun,
    input logic          timeout_pend,
    input logic [CW-1:0] rx_room
);

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        rx_count <= CW'(DEPTH)); // R2

    AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
        fifo_on && !cfg_wr && rx_count == CW'(DEPTH) && (rx_valid || rx_break) && !rd_en
        |=> rx_count == CW'(DEPTH) && overrun); // R2

    AST_MODE_FLIP_CLEAR: assert property (@(posedge clk) disable iff (rst)
        cfg_wr && (cfg_fifo_en != fifo_on) |=> rx_count == '0 && !data_ready); // R3

    AST_RX_CLEAR: assert property (@(posedge clk) disable iff (rst)
        cfg_wr && cfg_rx_reset
        |=> rx_count == '0 && !data_ready && !break_seen && !timeout_pend); // R4

    AST_BREAK_FLAGS: assert property (@(posedge clk) disable iff (rst)
        !cfg_wr && rx_break |=> break_seen && data_ready); // R5

    AST_EMPTY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        fifo_on && rx_count == '0 |-> !data_ready); // R6

    AST_READ_DROPS_PEND: assert property (@(posedge clk) disable iff (rst)
        !cfg_wr && rd_en |=> !timeout_pend); // R8

    AST_HOLD_OVERRUN: assert property (@(posedge clk) disable iff (rst)
        !fifo_on && !cfg_wr && data_ready && rx_valid && !rd_en |=> overrun); // R9

    AST_FULL_NO_ROOM: assert property (@(posedge clk) disable iff (rst)
        fifo_on && rx_count == CW'(DEPTH) |-> rx_room == '0); // R1

endmodule

bind uart_rx_buffer urb_checker #(.DEPTH(DEPTH)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .fifo_on      (fifo_on),
    .cfg_wr       (cfg_wr),
    .cfg_fifo_en  (cfg_fifo_en),
    .cfg_rx_reset (cfg_rx_reset),
    .rx_valid     (rx_valid),
    .rx_break     (rx_break),
    .rd_en        (rd_en),
    .rx_count     (rx_count),
    .data_ready   (data_ready),
    .break_seen   (break_seen),
    .overrun      (overrun),
    .timeout_pend (timeout_pend),
    .rx_room      (rx_room)
);

// File: tb/uart_rx_buffer_tb_top.sv
`timescale 1ns/1ps
module uart_rx_buffer_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_break = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_data;
    logic        stat_rd = 1'b0;
    logic        cfg_wr = 1'b0;
    logic        cfg_fifo_en = 1'b0;
    logic        cfg_rx_reset = 1'b0;
    logic [1:0]  cfg_trig = '0;
    logic [15:0] char_cycles = 16'd3;
    logic [4:0]  rx_count;
    logic        data_ready, break_seen, overrun, timeout_pend;
    logic [4:0]  rx_room;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    uart_rx_buffer dut_i (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_break(rx_break), .rd_en(rd_en), .rd_data(rd_data), .stat_rd(stat_rd),
        .cfg_wr(cfg_wr), .cfg_fifo_en(cfg_fifo_en), .cfg_rx_reset(cfg_rx_reset),
        .cfg_trig(cfg_trig), .char_cycles(char_cycles), .rx_count(rx_count),
        .data_ready(data_ready), .break_seen(break_seen), .overrun(overrun),
        .timeout_pend(timeout_pend), .rx_room(rx_room)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [7:0] mq[$];
    bit         m_fifo, m_dr, m_brk, m_ovr, m_pend, m_armed;
    int         m_lvl, m_tmr;
    logic [7:0] m_hold;

    function automatic int lvl_of(logic [1:0] s);
        case (s)
            2'd0: return 1;
            2'd1: return 4;
            2'd2: return 8;
            default: return 14;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            mq.delete();
            m_fifo = 0; m_dr = 0; m_brk = 0; m_ovr = 0; m_pend = 0;
            m_armed = 0; m_tmr = 0; m_lvl = 1; m_hold = 8'h00;
        end else if (cfg_wr && (cfg_rx_reset || cfg_fifo_en != m_fifo)) begin
            mq.delete();
            m_dr = 0; m_brk = 0; m_pend = 0; m_armed = 0; m_tmr = 0;
            m_fifo = cfg_fifo_en;
            m_lvl = lvl_of(cfg_trig);
        end else begin
            bit again;
            bit take;
            logic [7:0] b;
            again = 0;
            take = rx_valid || rx_break;
            b = rx_break ? 8'h00 : rx_data;
            if (cfg_wr) m_lvl = lvl_of(cfg_trig);
            if (stat_rd) begin m_ovr = 0; m_brk = 0; end
            if (m_fifo) begin
                if (rd_en) begin
                    if (mq.size() > 0) void'(mq.pop_front());
                    m_pend = 0;
                    if (mq.size() == 0) begin m_dr = 0; m_brk = 0; end
                    else again = 1;
                end
                if (take) begin
                    if (mq.size() < 16) mq.push_back(b);
                    else m_ovr = 1;
                    m_dr = 1;
                    if (rx_break) m_brk = 1;
                    again = 1;
                end
                if (again) begin
                    m_tmr = 0; m_armed = 1;
                end else if (m_armed) begin
                    if (m_tmr == 4 * int'(char_cycles) - 1) begin
                        m_armed = 0;
                        if (mq.size() > 0 && !rd_en) m_pend = 1;
                    end else m_tmr++;
                end
            end else begin
                if (rd_en) begin m_dr = 0; m_brk = 0; m_pend = 0; end
                if (take) begin
                    if (m_dr) m_ovr = 1;
                    m_hold = b;
                    m_dr = 1;
                    if (rx_break) m_brk = 1;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            int e_cnt, e_room, e_dat;
            e_cnt = m_fifo ? mq.size() : int'(m_dr);
            e_dat = m_fifo ? ((mq.size() > 0) ? int'(mq[0]) : 0) : int'(m_hold);
            if (m_fifo) e_room = (mq.size() == 16) ? 0 : (mq.size() <= m_lvl) ? m_lvl - mq.size() : 1;
            else        e_room = m_dr ? 0 : 1;
            chk("R2 model count", int'(rx_count), e_cnt);
            chk("R6 model rd_data", int'(rd_data), e_dat);
            chk("R6 model data_ready", int'(data_ready), int'(m_dr));
            chk("R5 model break", int'(break_seen), int'(m_brk));
            chk("R2 model overrun", int'(overrun), int'(m_ovr));
            chk("R7 model timeout", int'(timeout_pend), int'(m_pend));
            chk("R1 model room", int'(rx_room), e_room);
        end
    end

    // ---------------- stimulus ----------------
    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic idle(int n);
        repeat (n) step();
    endtask

    task automatic put(logic [7:0] b);
        rx_valid = 1'b1; rx_data = b; step(); rx_valid = 1'b0;
    endtask

    task automatic rd();
        rd_en = 1'b1; step(); rd_en = 1'b0;
    endtask

    task automatic cfg(bit en, bit clr, logic [1:0] t);
        cfg_wr = 1'b1; cfg_fifo_en = en; cfg_rx_reset = clr; cfg_trig = t;
        step();
        cfg_wr = 1'b0; cfg_rx_reset = 1'b0;
    endtask

    initial begin
        rst = 1'b1;
        idle(3);
        rst = 1'b0;
        step();
        chk("R11 reset count", int'(rx_count), 0);
        chk("R11 reset room", int'(rx_room), 1);
        chk("R11 reset flags", int'({data_ready, break_seen, overrun, timeout_pend}), 0);

        cfg(1, 0, 2'd1);
        chk("R1 level 4 empty room", int'(rx_room), 4);
        put(8'h11); put(8'h22); put(8'h33);
        chk("R1 room at 3 of 4", int'(rx_room), 1);
        put(8'h44);
        chk("R1 room at level", int'(rx_room), 0);
        put(8'h55);
        chk("R1 room above level", int'(rx_room), 1);

        idle(11);
        chk("R7 no timeout before window", int'(timeout_pend), 0);
        idle(1);
        chk("R7 timeout after 4 char times", int'(timeout_pend), 1);

        chk("R6 oldest byte first", int'(rd_data), 8'h11);
        rd();
        chk("R8 read clears timeout", int'(timeout_pend), 0);
        chk("R6 count after read", int'(rx_count), 4);

        for (int i = 0; i < 12; i++) put(8'h60 + 8'(i));
        chk("R2 full count", int'(rx_count), 16);
        chk("R1 full room", int'(rx_room), 0);
        put(8'hEE);
        chk("R2 count kept on overflow", int'(rx_count), 16);
        chk("R2 overrun set", int'(overrun), 1);
        for (int i = 0; i < 16; i++) begin
            if (i == 0)  chk("R2 head kept", int'(rd_data), 8'h22);
            if (i == 15) chk("R2 last stored byte not replaced", int'(rd_data), 8'h6B);
            rd();
        end
        chk("R6 empty after drain", int'(rx_count), 0);
        chk("R6 ready cleared at zero", int'(data_ready), 0);
        chk("R6 empty read data", int'(rd_data), 0);

        stat_rd = 1'b1; step(); stat_rd = 1'b0;
        chk("R10 status read clears overrun", int'(overrun), 0);

        rx_break = 1'b1; step(); rx_break = 1'b0;
        chk("R5 break byte stored", int'(rx_count), 1);
        chk("R5 break flags", int'({break_seen, data_ready}), 3);
        chk("R5 break byte is zero", int'(rd_data), 0);
        rd();
        chk("R6 break cleared on empty", int'(break_seen), 0);

        put(8'h71);
        rx_valid = 1'b1; rx_data = 8'h72; rd_en = 1'b1;
        step();
        rx_valid = 1'b0; rd_en = 1'b0;
        chk("R12 read then store count", int'(rx_count), 1);
        chk("R12 new byte at head", int'(rd_data), 8'h72);

        put(8'h73);
        chk("R4 pre-clear count", int'(rx_count), 2);
        cfg(1, 1, 2'd1);
        chk("R4 clear empties", int'(rx_count), 0);
        chk("R4 clear flags", int'({data_ready, break_seen, timeout_pend}), 0);
        idle(14);
        chk("R4 no timeout after clear", int'(timeout_pend), 0);

        put(8'h74);
        cfg(0, 0, 2'd1);
        chk("R3 mode switch empties", int'(rx_count), 0);
        chk("R3 mode switch ready low", int'(data_ready), 0);

        put(8'h81);
        chk("R9 holding ready", int'(data_ready), 1);
        chk("R9 holding room", int'(rx_room), 0);
        chk("R9 holding data", int'(rd_data), 8'h81);
        put(8'h82);
        chk("R9 holding overrun", int'(overrun), 1);
        chk("R9 holding overwritten", int'(rd_data), 8'h82);
        rd();
        chk("R9 read clears ready", int'(data_ready), 0);

        stat_rd = 1'b1; step(); stat_rd = 1'b0;
        chk("R10 overrun cleared", int'(overrun), 0);
        put(8'h83);
        stat_rd = 1'b1; rx_valid = 1'b1; rx_data = 8'h84;
        step();
        stat_rd = 1'b0; rx_valid = 1'b0;
        chk("R10 new overrun wins over clear", int'(overrun), 1);

        cfg(1, 0, 2'd3);
        chk("R1 level 14 room", int'(rx_room), 14);
        cfg(1, 0, 2'd2);
        chk("R1 level 8 room", int'(rx_room), 8);
        cfg(1, 0, 2'd0);
        chk("R1 level 1 room", int'(rx_room), 1);

        idle(2);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R11 actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule